// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its module clock. A single control word holds two divisor fields and a law-select bit. With the select bit set, the divide law is linear: the module clock is divided by 2*(n+1). With the bit clear, the law is exponential: the module clock is divided by 2^(n+1). Both laws produce a clock with a 50% duty cycle. The fastest clock the block can make is half the module clock, with the linear law and n = 0.

The serial clock rests at the polarity level (`cpol_i`) whenever the generator is disabled. Each period starts by leaving that level, which is the leading edge, and ends by returning to it, which is the trailing edge. Two registered single-cycle strobes mark these edges for the shift logic around the block:
- `sample_stb_o` marks the leading edge. Data is sampled here under a phase-0 convention.
- `shift_stb_o` marks the trailing edge. The next bit is launched here.

The divisor is captured when the generator starts and again at every trailing edge. A change to the control word while a period is running therefore never shortens or stretches that period.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `sample_stb_o` and `shift_stb_o` are all 0. In any cycle after a clock edge at which `en_i` was low, `sclk_o` equals the `cpol_i` sampled at that edge and both strobes are 0.
- R2: With control bit 12 = 1 (linear law), `sclk_o` toggles every n+1 module cycles, where n = control bits [7:0]. Bits [11:8] have no effect in this law.
- R3: With control bit 12 = 0 (exponential law), `sclk_o` toggles every 2^n module cycles, where n = control bits [11:8]. Bits [7:0] have no effect in this law.
- R4: Let E0 be the first clock edge at which `en_i` is sampled high after being low. `sclk_o` stays at the idle level after E0. Its first change comes h edges after E0, where h is the half period decoded from the control word at E0.
- R5: `sample_stb_o` is high for exactly the one cycle in which `sclk_o` first shows the level it took on at a leading edge. `shift_stb_o` is high for exactly the one cycle in which `sclk_o` first shows the level it took on at a trailing edge. The two strobes are never high together, and `sclk_o` never changes while enabled without one of them.
- R6: A control word change during a period takes effect only from the trailing edge that ends that period. Both halves of the running period keep the previous half length.
- R7: Dropping `en_i` in the middle of a period returns `sclk_o` to `cpol_i` after the next edge with no strobe. A later enable starts again with a full first half.
- R8: The linear law with n = 0 gives a clock of half the module rate, with one strobe in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run the serial clock; low forces the idle level |
| cpol_i | input | 1 | Idle level of the serial clock |
| ctrl_i | input | 13 | [7:0] linear n, [11:8] exponential n, [12] law select (1 linear) |
| sclk_o | output | 1 | Serial clock |
| sample_stb_o | output | 1 | One-cycle strobe at each leading edge |
| shift_stb_o | output | 1 | One-cycle strobe at each trailing edge |

## Verification
The bench sweeps the linear law and the exponential law across many divisor values and compares every cycle against an edge schedule computed from the half length. This sweep exposes these faults:
- an off-by-one in either law, which would drift the toggle instants;
- a swapped select sense, or a field read from the wrong bits; the unused field is filled with unrelated values during each run to catch this.

The n = 0 linear case and the largest exponential divisor are also checked. A wrong counter width would fold the longest half period back to a short one.

Two further directed cases cover the other corner behaviours:
- A divisor change in mid-period. A design that reloaded at once would put a leading edge too early.
- A disable in mid-high-phase. A leaky design would hold the active level or emit a stray strobe.

// File: rtl/spi_sclk_pkg.sv
`timescale 1ns/1ps
package spi_sclk_pkg;

    typedef enum logic {
        LAW_EXPONENTIAL = 1'b0,
        LAW_LINEAR      = 1'b1
    } div_law_e;

endpackage

// File: rtl/spi_sclk_decode.sv
`timescale 1ns/1ps
module spi_sclk_decode
    import spi_sclk_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int CTRL_W = LIN_W + EXP_W + 1,
    parameter int HALF_W = 16
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [HALF_W-1:0] half_o
);
    localparam int SEL_BIT = LIN_W + EXP_W;

    logic [LIN_W-1:0]  lin_n;
    logic [EXP_W-1:0]  exp_n;
    div_law_e          law;
    logic [HALF_W-1:0] lin_half;
    logic [HALF_W-1:0] exp_half;

    always_comb begin
        lin_n    = ctrl_i[LIN_W-1:0];
        exp_n    = ctrl_i[LIN_W +: EXP_W];
        law      = div_law_e'(ctrl_i[SEL_BIT]);
        lin_half = HALF_W'(lin_n) + HALF_W'(1);
        exp_half = HALF_W'(1) << exp_n;
        half_o   = (law == LAW_LINEAR) ? lin_half : exp_half;
    end

endmodule

// File: rtl/spi_sclk_core.sv
`timescale 1ns/1ps
module spi_sclk_core #(
    parameter int HALF_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              sclk_o,
    output logic              lead_o,
    output logic              trail_o
);
    typedef struct packed {
        logic              run;
        logic              phase;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
        logic              sclk;
        logic              lead;
        logic              trail;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!en_i) begin
            st_d.run   = 1'b0;
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
        end else if (!st_q.run) begin
            st_d.run  = 1'b1;
            st_d.half = half_i;
            st_d.cnt  = half_i - HALF_W'(1);
        end else if (st_q.cnt == '0) begin
            st_d.phase = ~st_q.phase;
            if (!st_q.phase) begin
                st_d.lead = 1'b1;
                st_d.cnt  = st_q.half - HALF_W'(1);
            end else begin
                st_d.trail = 1'b1;
                st_d.half  = half_i;
                st_d.cnt   = half_i - HALF_W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - HALF_W'(1);
        end
        st_d.sclk = cpol_i ^ st_d.phase;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o  = st_q.sclk;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;

endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int CTRL_W = LIN_W + EXP_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              sclk_o,
    output logic              sample_stb_o,
    output logic              shift_stb_o
);
    localparam int LIN_MAX = LIN_W + 1;
    localparam int EXP_MAX = (1 << EXP_W);
    localparam int HALF_W  = (LIN_MAX > EXP_MAX) ? LIN_MAX : EXP_MAX;

    logic [HALF_W-1:0] half;

    spi_sclk_decode #(
        .LIN_W  (LIN_W),
        .EXP_W  (EXP_W),
        .CTRL_W (CTRL_W),
        .HALF_W (HALF_W)
    ) u_decode (
        .ctrl_i (ctrl_i),
        .half_o (half)
    );

    spi_sclk_core #(
        .HALF_W (HALF_W)
    ) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .cpol_i  (cpol_i),
        .half_i  (half),
        .sclk_o  (sclk_o),
        .lead_o  (sample_stb_o),
        .trail_o (shift_stb_o)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic cpol_i,
    input logic sclk_o,
    input logic sample_stb_o,
    input logic shift_stb_o
);
    logic [1:0] seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= 2'd0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    a_r5_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_stb_o && shift_stb_o));

    a_r5_sample_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |=> !sample_stb_o);

    a_r5_shift_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_stb_o |=> !shift_stb_o);

    a_r1_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (sclk_o == $past(cpol_i) && !sample_stb_o && !shift_stb_o));

    a_r4_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q == 2'd3 && $rose(en_i)) |=>
            (sclk_o == $past(cpol_i) && !sample_stb_o && !shift_stb_o));

    a_r5_edge_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q == 2'd3 && $past(en_i) && $past(cpol_i) == $past(cpol_i, 2)
            && sclk_o != $past(sclk_o)) |-> (sample_stb_o || shift_stb_o));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cpol_i       (cpol_i),
    .sclk_o       (sclk_o),
    .sample_stb_o (sample_stb_o),
    .shift_stb_o  (shift_stb_o)
);

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] ctrl = '0;
    logic        sclk, samp, shft;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spi_sclk_gen dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .en_i         (en),
        .cpol_i       (cpol),
        .ctrl_i       (ctrl),
        .sclk_o       (sclk),
        .sample_stb_o (samp),
        .shift_stb_o  (shft)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pack3(input logic s, input logic a, input logic b);
        return {29'd0, s, a, b};
    endfunction

    // Idle, then enable and compare each cycle against the edge schedule.
    task automatic sweep(input logic [12:0] cw, input logic pol, input int h,
                         input int nper, input string req);
        @(negedge clk);
        en = 1'b0; cpol = pol; ctrl = cw;
        @(negedge clk);
        @(negedge clk);
        check(sclk == pol && !samp && !shft, "R1 idle", pack3(sclk, samp, shft), pack3(pol, 0, 0));
        en = 1'b1;
        @(negedge clk);
        check(sclk == pol && !samp && !shft, "R4 start", pack3(sclk, samp, shft), pack3(pol, 0, 0));
        for (int k = 1; k <= 2 * nper * h; k++) begin
            int  q;
            bit  ph, ex_l, ex_t;
            @(negedge clk);
            q    = k / h;
            ph   = q[0];
            ex_l = (k % h == 0) && q[0];
            ex_t = (k % h == 0) && !q[0];
            check(pack3(sclk, samp, shft) == pack3(pol ^ ph, ex_l, ex_t),
                  {req, " R5"}, pack3(sclk, samp, shft), pack3(pol ^ ph, ex_l, ex_t));
        end
        en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sclk == 1'b0 && !samp && !shft, "R1 reset", pack3(sclk, samp, shft), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1 && !samp && !shft, "R1 after reset", pack3(sclk, samp, shft), 4);

        // R8: fastest clock, strobe every cycle
        sweep(13'h1000, 1'b0, 1, 4, "R8");
        // R2: linear law, exponential field filled with unrelated bits
        for (int n = 0; n < 64; n++) begin
            logic [7:0] nb;
            nb = 8'(n);
            sweep({1'b1, ~nb[3:0], nb}, n[1], n + 1, 2, "R2");
        end
        sweep({1'b1, 4'h9, 8'hFF}, 1'b1, 256, 1, "R2");
        // R3: exponential law, linear field filled with unrelated bits
        for (int n = 0; n < 12; n++) begin
            logic [3:0] nb;
            nb = 4'(n);
            sweep({1'b0, nb, 8'hA5 ^ {nb, nb}}, n[0], 1 << n, 2, "R3");
        end
        sweep({1'b0, 4'hF, 8'h3C}, 1'b0, 1 << 15, 1, "R3");

        // R6: change from h=4 to h=2 during the first half period
        @(negedge clk);
        en = 1'b0; cpol = 1'b0; ctrl = {1'b1, 4'h0, 8'd3};
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 13; k++) begin
            bit ph, el, et;
            @(negedge clk);
            if (k == 2) ctrl = {1'b1, 4'h0, 8'd1};
            ph = (k >= 4 && k < 8) || (k >= 10 && k < 12);
            el = (k == 4) || (k == 10);
            et = (k == 8) || (k == 12);
            check(pack3(sclk, samp, shft) == pack3(ph, el, et), "R6",
                  pack3(sclk, samp, shft), pack3(ph, el, et));
        end

        // R7: disable during the active phase, h=3
        @(negedge clk);
        en = 1'b0; cpol = 1'b1; ctrl = {1'b1, 4'h0, 8'd2};
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        repeat (4) @(negedge clk);
        check(sclk == 1'b0 && !samp && !shft, "R7 active", pack3(sclk, samp, shft), 0);
        en = 1'b0;
        @(negedge clk);
        check(sclk == 1'b1 && !samp && !shft, "R7 dropped", pack3(sclk, samp, shft), 4);
        @(negedge clk);
        check(sclk == 1'b1 && !samp && !shft, "R7 held", pack3(sclk, samp, shft), 4);
        sweep({1'b1, 4'h0, 8'd2}, 1'b1, 3, 2, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule